// File: doc/BRIEF.md
# Parallel-Port Peripheral Handshake Controller

This block sits on the peripheral side of an 8-bit enhanced parallel port and runs on the system clock. The host marks each transfer by pulling one of two active-low strobes: one for address cycles, one for data cycles. A direction line says whether the host writes or reads. The strobes are slow and asynchronous to the system clock. The block passes them and the direction line through two-flop synchronisers and acts on the synchronised falling edge. For a host write it latches the byte on the bus and reports it with a single-cycle valid pulse. For a host data read it raises a one-cycle request to the fabric, takes the returned byte and drives it onto the bus.

The shared bus is split into an input, an output and an output enable, so the pad ring can build the tristate buffer. The handshake line rises once a write byte is latched or a read byte is driven. It falls after the synchronised strobe returns high. The output enable drops one clock after that, which gives the host a clean turnaround. An address strobe with the read direction completes the handshake but captures nothing.

Top module: `epp_periph_ctrl`

## Requirements
- R1: After reset `addr_vld`, `data_vld`, `rd_req`, `wait_o` and `bus_oe` are 0, and `addr_q`, `data_q` and `bus_out` are 0.
- R2: An address strobe low with `host_rd` = 0 loads `bus_in` into `addr_q` and produces exactly one `addr_vld` pulse.
- R3: A data strobe low with `host_rd` = 0 loads `bus_in` into `data_q` and produces exactly one `data_vld` pulse, with no `rd_req`.
- R4: A data strobe low with `host_rd` = 1 produces exactly one `rd_req` pulse and no `data_vld`. On the clock that ends the `rd_req` cycle, `rd_byte` is loaded into `bus_out` and `bus_oe` rises.
- R5: `wait_o` is 1 from the cycle the byte is latched or driven until the strobe is released. It is 0 on the third clock edge after the strobe rises.
- R6: `bus_oe` stays 1 for exactly one clock after `wait_o` falls on a read, and is 0 during all write and address cycles.
- R7: An address strobe with `host_rd` = 1 gives no `addr_vld` and leaves `addr_q` unchanged, but still raises and lowers `wait_o`.
- R8: Each valid pulse lasts exactly one clock however long the strobe is held low.
- R9: A valid or request pulse becomes visible three clock edges after the strobe falls: two synchroniser stages plus one edge-detect register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| astb_n | input | 1 | Host address strobe, active low, asynchronous |
| dstb_n | input | 1 | Host data strobe, active low, asynchronous |
| host_rd | input | 1 | Transfer direction: 1 = host reads, 0 = host writes |
| bus_in | input | W | Byte seen on the shared bus |
| bus_out | output | W | Byte driven toward the host on reads |
| bus_oe | output | 1 | Output enable for the shared bus buffer |
| wait_o | output | 1 | Handshake acknowledge to the host |
| rd_byte | input | W | Read data supplied by the fabric |
| rd_req | output | 1 | One-cycle request for a read byte |
| addr_q | output | W | Last captured address byte |
| addr_vld | output | 1 | One-cycle pulse on address capture |
| data_q | output | W | Last captured data byte |
| data_vld | output | 1 | One-cycle pulse on data capture |

## Verification
The hardest situation to reach is the bus turnaround at the end of a read. There, `wait_o` has already dropped while `bus_oe` must still be held for exactly one more clock, and this window exists only after a full synchronised strobe release. Each host transfer is a bench task that holds the strobe for many clocks. It then releases the strobe and samples the handshake and the enable on the third and fourth clock edges after release. Random sequences mix address writes, address reads, data writes and data reads back to back, so a read turnaround is often followed at once by a write on the same bus.

// File: rtl/epp_periph_ctrl.sv
module epp_periph_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         astb_n,
  input  logic         dstb_n,
  input  logic         host_rd,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic         wait_o,
  input  logic [W-1:0] rd_byte,
  output logic         rd_req,
  output logic [W-1:0] addr_q,
  output logic         addr_vld,
  output logic [W-1:0] data_q,
  output logic         data_vld
);

  logic [1:0] a_sy, d_sy, r_sy;
  logic       a_prev, d_prev, rel_d;

  wire rd_dir = r_sy[1];
  wire a_fall = a_prev & ~a_sy[1];
  wire a_rise = ~a_prev & a_sy[1];
  wire d_fall = d_prev & ~d_sy[1];
  wire d_rise = ~d_prev & d_sy[1];
  wire a_wr   = a_fall & ~rd_dir;
  wire d_wr   = d_fall & ~rd_dir;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      a_sy     <= 2'b11;
      d_sy     <= 2'b11;
      r_sy     <= 2'b00;
      a_prev   <= 1'b1;
      d_prev   <= 1'b1;
      rel_d    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      addr_vld <= 1'b0;
      data_vld <= 1'b0;
      rd_req   <= 1'b0;
      wait_o   <= 1'b0;
      bus_oe   <= 1'b0;
      bus_out  <= '0;
    end else begin
      a_sy     <= {a_sy[0], astb_n};
      d_sy     <= {d_sy[0], dstb_n};
      r_sy     <= {r_sy[0], host_rd};
      a_prev   <= a_sy[1];
      d_prev   <= d_sy[1];
      rel_d    <= d_rise;
      addr_vld <= a_wr;
      data_vld <= d_wr;
      rd_req   <= d_fall & rd_dir;
      if (a_wr) addr_q <= bus_in;
      if (d_wr) data_q <= bus_in;
      if (a_fall | d_wr | rd_req) wait_o <= 1'b1;
      else if (a_rise | d_rise)   wait_o <= 1'b0;
      if (rd_req) begin
        bus_oe  <= 1'b1;
        bus_out <= rd_byte;
      end else if (rel_d) begin
        bus_oe  <= 1'b0;
      end
    end
  end

endmodule

module epp_periph_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic addr_vld,
  input logic data_vld,
  input logic rd_req,
  input logic wait_o,
  input logic bus_oe
);

  assert_addr_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    addr_vld |=> !addr_vld);

  assert_data_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    data_vld |=> !data_vld);

  assert_req_drives_bus_R4: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> (!rd_req && bus_oe && wait_o));

  assert_no_read_capture_R4: assert property (@(posedge clk) disable iff (rst)
    !(data_vld && rd_req));

  assert_wait_on_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (addr_vld || data_vld) |-> wait_o);

  assert_release_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && !wait_o) |=> !bus_oe);

  assert_no_drive_on_write_R6: assert property (@(posedge clk) disable iff (rst)
    (addr_vld || data_vld) |-> !bus_oe);

endmodule

bind epp_periph_ctrl epp_periph_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .addr_vld(addr_vld), .data_vld(data_vld),
  .rd_req(rd_req), .wait_o(wait_o), .bus_oe(bus_oe)
);

// File: tb/epp_periph_ctrl_tb.sv
`timescale 1ns/1ps
module epp_periph_ctrl_tb_top;
  localparam int W = 8;
  localparam int HOLD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic astb_n = 1'b1, dstb_n = 1'b1, host_rd = 1'b0;
  logic [W-1:0] bus_in = '0, rd_byte = '0;
  logic [W-1:0] bus_out, addr_q, data_q;
  logic bus_oe, wait_o, rd_req, addr_vld, data_vld;

  int checks = 0, errors = 0, cyc = 0;
  int a_cnt, d_cnt, q_cnt, a_cyc, d_cyc, q_cyc, wid_err;
  logic pa, pd, pq;
  logic [W-1:0] exp_addr = '0, exp_data = '0;

  epp_periph_ctrl #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .astb_n(astb_n), .dstb_n(dstb_n), .host_rd(host_rd),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .wait_o(wait_o),
    .rd_byte(rd_byte), .rd_req(rd_req), .addr_q(addr_q), .addr_vld(addr_vld),
    .data_q(data_q), .data_vld(data_vld));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (addr_vld) begin a_cnt++; a_cyc = cyc; if (pa) wid_err++; end
      if (data_vld) begin d_cnt++; d_cyc = cyc; if (pd) wid_err++; end
      if (rd_req)   begin q_cnt++; q_cyc = cyc; if (pq) wid_err++; end
      pa = addr_vld; pd = data_vld; pq = rd_req;
    end
  end

  function automatic int exp_pulses(input bit is_addr, input bit rd, input bit want_addr,
                                    input bit want_data, input bit want_req);
    if (want_addr) return (is_addr && !rd) ? 1 : 0;
    if (want_data) return (!is_addr && !rd) ? 1 : 0;
    if (want_req)  return (!is_addr && rd) ? 1 : 0;
    return 0;
  endfunction

  function automatic int exp_latency();
    return 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_cycle(input bit is_addr, input bit rd, input logic [W-1:0] val,
                            input logic [W-1:0] rv);
    int fall_cyc;
    @(negedge clk);
    host_rd = rd;
    bus_in  = rd ? ~val : val;
    rd_byte = rv;
    a_cnt = 0; d_cnt = 0; q_cnt = 0; wid_err = 0;
    pa = 0; pd = 0; pq = 0;
    repeat (2) @(negedge clk);
    fall_cyc = cyc;
    if (is_addr) astb_n = 1'b0; else dstb_n = 1'b0;
    repeat (HOLD) @(negedge clk);
    chk(wait_o == 1'b1, "R5 wait held", wait_o, 1);
    chk(a_cnt == exp_pulses(is_addr, rd, 1, 0, 0), "R2/R7 addr_vld count", a_cnt,
        exp_pulses(is_addr, rd, 1, 0, 0));
    chk(d_cnt == exp_pulses(is_addr, rd, 0, 1, 0), "R3 data_vld count", d_cnt,
        exp_pulses(is_addr, rd, 0, 1, 0));
    chk(q_cnt == exp_pulses(is_addr, rd, 0, 0, 1), "R4 rd_req count", q_cnt,
        exp_pulses(is_addr, rd, 0, 0, 1));
    chk(wid_err == 0, "R8 pulse width", wid_err, 0);
    if (is_addr && !rd) begin
      exp_addr = val;
      chk(a_cyc - fall_cyc == exp_latency(), "R9 addr latency", a_cyc - fall_cyc, exp_latency());
    end
    if (!is_addr && !rd) begin
      exp_data = val;
      chk(d_cyc - fall_cyc == exp_latency(), "R9 data latency", d_cyc - fall_cyc, exp_latency());
    end
    chk(addr_q == exp_addr, "R2/R7 addr_q", addr_q, exp_addr);
    chk(data_q == exp_data, "R3 data_q", data_q, exp_data);
    if (!is_addr && rd) begin
      chk(q_cyc - fall_cyc == exp_latency(), "R9 req latency", q_cyc - fall_cyc, exp_latency());
      chk(bus_oe == 1'b1, "R4 bus_oe on read", bus_oe, 1);
      chk(bus_out == rv, "R4 bus_out", bus_out, rv);
    end else begin
      chk(bus_oe == 1'b0, "R6 no drive on write", bus_oe, 0);
    end
    rd_byte = ~rv;
    if (is_addr) astb_n = 1'b1; else dstb_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(wait_o == 1'b1, "R5 wait until sync release", wait_o, 1);
    @(negedge clk);
    chk(wait_o == 1'b0, "R5 wait released", wait_o, 0);
    chk(bus_oe == (!is_addr && rd), "R6 bus_oe one extra clock", bus_oe, (!is_addr && rd));
    if (!is_addr && rd) chk(bus_out == rv, "R4 bus_out held", bus_out, rv);
    @(negedge clk);
    chk(bus_oe == 1'b0, "R6 bus_oe released", bus_oe, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(addr_vld == 0 && data_vld == 0 && rd_req == 0, "R1 reset pulses", {addr_vld, data_vld, rd_req}, 0);
    chk(wait_o == 0 && bus_oe == 0, "R1 reset handshake", {wait_o, bus_oe}, 0);
    chk(addr_q == 0 && data_q == 0 && bus_out == 0, "R1 reset regs", addr_q | data_q | bus_out, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(addr_vld == 0 && wait_o == 0 && bus_oe == 0, "R1 idle after reset", {addr_vld, wait_o, bus_oe}, 0);

    host_cycle(1, 0, 8'hA5, 8'h00);
    host_cycle(0, 0, 8'h3C, 8'h00);
    host_cycle(0, 1, 8'h00, 8'hC3);
    host_cycle(1, 1, 8'h77, 8'h00);
    host_cycle(0, 1, 8'h00, 8'hFF);
    host_cycle(0, 0, 8'h00, 8'h00);
    host_cycle(1, 0, 8'hFF, 8'h00);

    for (int i = 0; i < 40; i++) begin
      bit ia, rd;
      logic [W-1:0] v, r;
      ia = 1'($urandom);
      rd = 1'($urandom);
      v  = W'($urandom);
      r  = W'($urandom);
      host_cycle(ia, rd, v, r);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule